// File: doc/BRIEF.md
# I2C Serial EEPROM Target Model

This block is a synthesizable I2C target that answers like a small serial EEPROM. It lets an I2C master design be tested against a known responder in simulation or on silicon. A fast system clock oversamples the two bus lines. The block finds START, repeated START and STOP conditions. It compares the first byte of each transfer against its own 7-bit address and then either stores the bytes the master writes or returns bytes from its internal byte array.

The memory address that follows the device byte is one or two bytes long, set by a parameter. A write sets the address and then stores data bytes in order. A random read first loads the address in a write phase, then switches direction after a repeated START. The address pointer steps after every data byte. For writes it wraps inside one page, and for reads it wraps at the top of the array.

The block never drives SDA high. Its single output is an open-drain enable: when it is 1, SDA is pulled low.

Top module: `i2c_eeprom_target`

## Requirements
- R1: During and after reset, `sda_oe` is 0, and no transfer is in progress until a START is seen.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. A START at any point, including a repeated START, restarts decoding with a device byte. A STOP releases SDA and returns to idle.
- R3: The first byte after a START is seven address bits, MSB first, then a direction bit (0 = write, 1 = read). When the seven bits equal `DEV_ADDR` (default 7'b1010011), the target acknowledges by holding `sda_oe` at 1 for the ninth SCL pulse.
- R4: When the device address does not match, the target gives no acknowledge on that byte or any later byte, leaves the memory unchanged, and stays silent until the next START.
- R5: With `ADDR_BYTES` = 2, the high address byte comes first and then the low byte, and each one is acknowledged. With `ADDR_BYTES` = 1, only one address byte follows.
- R6: In a write, every data byte after the address is acknowledged and stored at the current pointer.
- R7: After each written byte, the pointer steps by one. It wraps within its `PAGE_SIZE`-aligned page, so the page bits stay fixed.
- R8: A random read returns the byte at the loaded address, MSB first. The sequence is: device byte with write, address bytes, repeated START, then device byte with read.
- R9: In a read, each byte acknowledged by the master is followed by the next address. The pointer wraps from the last location to 0.
- R10: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START, so further clocks read back all ones.
- R11: `sda_oe` changes only while SCL is low, and SDA is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release it |

## Verification
The checks assume the master holds each SCL level for several system clocks longer than the two-flop synchronizer delay. This is what lets the target's enable change settle while SCL is still low. They also assume the master changes SDA only while SCL is low, except when it means to signal a START or STOP. The bench master paces every bus phase at ten system clocks. It changes SDA a full phase after each SCL fall, and it makes START and STOP only with SCL high and steady. This keeps every transfer inside those assumptions.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter logic [6:0] DEV_ADDR   = 7'b1010011,
  parameter int         ADDR_BYTES = 2,
  parameter int         MEM_DEPTH  = 256,
  parameter int         PAGE_SIZE  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_SIZE - 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_AHI = 3'd2,
                         S_ALO = 3'd3, S_WR = 3'd4, S_RD = 3'd5;

  logic [2:0] scl_q, sda_q, state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, addr_hi;
  logic [AW-1:0] ptr;
  logic mack;
  logic [7:0] mem [MEM_DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire dev_hit   = shreg[7:1] == DEV_ADDR;
  wire [AW-1:0] ptr_inc  = ptr + 1'b1;
  wire [AW-1:0] page_inc = (ptr & ~PMASK) | (ptr_inc & PMASK);
  wire [15:0]   new_addr = {addr_hi, shreg};
  wire [7:0]    rd_byte  = mem[ptr];

  always_ff @(posedge clk)
    if (rst_n && state == S_WR && scl_fall && bitcnt == 4'd8)
      mem[ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      addr_hi <= '0;
      ptr     <= '0;
      mack    <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (scl_rise) begin
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_q[1]};
        else               mack  <= sda_q[1];
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (state)
            S_DEV: begin
              sda_oe <= dev_hit;
              if (!dev_hit)      state <= S_IDLE;
              else if (shreg[0]) state <= S_RD;
              else               state <= (ADDR_BYTES == 2) ? S_AHI : S_ALO;
            end
            S_AHI: begin
              sda_oe  <= 1'b1;
              addr_hi <= shreg;
              state   <= S_ALO;
            end
            S_ALO: begin
              sda_oe <= 1'b1;
              ptr    <= AW'(new_addr);
              state  <= S_WR;
            end
            S_WR: begin
              sda_oe <= 1'b1;
              ptr    <= page_inc;
            end
            S_RD: begin
              sda_oe <= 1'b0;
              ptr    <= ptr_inc;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == S_RD && !mack) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            sda_oe <= 1'b0;
            if (state == S_RD) state <= S_IDLE;
          end
        end else if (bitcnt != 4'd0 && state == S_RD) begin
          tx     <= {tx[6:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
endmodule

module i2c_eeprom_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [2:0] state,
  input logic [3:0] bitcnt,
  input logic       start_det,
  input logic       stop_det
);
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  a_r2_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == 3'd1 && bitcnt == 4'd0 && !sda_oe));
  a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == 3'd0 && !sda_oe));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);
  a_r3_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .state(state),
  .bitcnt(bitcnt), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'b1010011;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int   checks = 0, errors = 0, r11_bad = 0;
  bit   done = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  event got_ev;

  always #2 clk = ~clk;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = nack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    logic ack;
    bus_start();
    wbyte({DEV, 1'b0}, ack); chk("R3 dev write ack", {7'd0, ack}, 8'd1);
    wbyte(a[15:8], ack);     chk("R5 addr high ack", {7'd0, ack}, 8'd1);
    wbyte(a[7:0], ack);      chk("R5 addr low ack", {7'd0, ack}, 8'd1);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d0, d1, d2, input int n);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    addr_phase(a);
    for (int k = 0; k < n; k++) begin
      wbyte(d[k], ack); chk("R6 data ack", {7'd0, ack}, 8'd1);
    end
    bus_stop();
    chk("R2 released after stop", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input bit extra);
    logic ack;
    logic [7:0] b;
    addr_phase(a);
    bus_start();
    wbyte({DEV, 1'b1}, ack); chk("R2 restart dev read ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, b);
      got_q.push_back(b);
      ->got_ev;
    end
    chk("R10 released after nack", {7'd0, sda_oe}, 8'd0);
    if (extra) begin
      rbyte(1'b1, b);
      chk("R10 silent after nack", b, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin : monitor
    forever begin
      @(got_ev);
      tick(1);
      while (got_q.size() > 0) begin
        if (exp_q.size() == 0) chk("scoreboard underflow", got_q.pop_front(), 8'hxx);
        else chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) r11_bad++;
    prev_oe <= sda_oe;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    tick(190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin : driver
    logic ack;
    tick(5);
    chk("R1 reset oe", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 idle oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 bus high", {7'd0, sda_bus}, 8'd1);

    do_write(16'h0010, 8'hA5, 8'h00, 8'h00, 1);
    expect_byte(8'hA5, "R8 random read");
    do_read(16'h0010, 1, 1'b1);

    do_write(16'h0020, 8'h11, 8'h22, 8'h33, 3);
    expect_byte(8'h11, "R9 seq read 0");
    expect_byte(8'h22, "R9 seq read 1");
    expect_byte(8'h33, "R9 seq read 2");
    do_read(16'h0020, 3, 1'b0);

    do_write(16'h003E, 8'h44, 8'h55, 8'h66, 3);
    expect_byte(8'h66, "R7 page wrap to page start");
    do_read(16'h0038, 1, 1'b0);
    expect_byte(8'h55, "R7 last in page");
    do_read(16'h003F, 1, 1'b0);

    do_write(16'h00FF, 8'h77, 8'h00, 8'h00, 1);
    do_write(16'h0000, 8'h88, 8'h00, 8'h00, 1);
    expect_byte(8'h77, "R9 top of memory");
    expect_byte(8'h88, "R9 wrap to zero");
    do_read(16'h00FF, 2, 1'b0);

    bus_start();
    wbyte({7'h50, 1'b0}, ack); chk("R4 no ack wrong dev", {7'd0, ack}, 8'd0);
    wbyte(8'h00, ack);         chk("R4 no ack after miss", {7'd0, ack}, 8'd0);
    wbyte(8'h10, ack);         chk("R4 no ack after miss", {7'd0, ack}, 8'd0);
    wbyte(8'h5A, ack);         chk("R4 no ack after miss", {7'd0, ack}, 8'd0);
    bus_stop();
    expect_byte(8'hA5, "R4 memory unchanged");
    do_read(16'h0010, 1, 1'b0);

    tick(4*Q);
    chk("R11 oe changed only with scl low", r11_bad[7:0], 8'd0);
    chk("scoreboard drained", exp_q.size() == 0 ? 8'd0 : 8'd1, 8'd0);
    finish_run();
  end
endmodule